// File: doc/BRIEF.md
# UART Software Flow Control Engine

This block sits between a UART receiver, its receive FIFO and its transmitter and runs in-band (Xon/Xoff) flow control without software help. Every received character passes through it on the way to the receive FIFO. Characters that match the programmed stop or go codes are held back from the FIFO, and they pause or release the local transmitter. In double-character mode a code is only recognised as two characters in a row. A first character that matches but is not followed by its partner is passed on as ordinary data, together with the character that broke the pair.

In the other direction the block watches the receive FIFO fill level. When the level climbs to the programmed halt threshold it asks the transmitter to slip the stop code(s) into the outgoing stream. When the level drains to the resume threshold it asks for the go code(s). Such an injected character goes ahead of the transmit FIFO and is sent even while the local transmitter is paused. The four code registers keep their contents across reset.

Top module: `uart_swflow`

## Requirements
- R1: In single mode with receive flow control enabled (`cfg_rx_en`=1, `cfg_double`=0), a received character equal to the stop code (slot 2) sets `tx_halt` at the clock edge that samples the strobe, and it is not forwarded to the FIFO.
- R2: While `tx_halt` is 1, a received go code (slot 0 in single mode) clears `tx_halt` and `fc_flag` and is not forwarded. A go code received while `tx_halt` is 0 is forwarded as data.
- R3: In double mode (`cfg_double`=1), stop takes slot 2 followed directly by slot 3, and go (only while halted) takes slot 0 followed by slot 1. Both characters of a matched pair are withheld from the FIFO.
- R4: In double mode, if a first character matches but the next does not complete its pair, the partial match is dropped. Both characters are forwarded in arrival order, and `tx_halt` is unchanged.
- R5: Comparisons use only the low 5, 6, 7 or 8 bits, for `cfg_wlen` = 0, 1, 2, 3. Forwarded data keeps all 8 bits.
- R6: A stop match sets `fc_flag` only when `cfg_irq_en` is 1. `fc_flag` is never 1 while `tx_halt` is 0.
- R7: With `cfg_tx_auto`=1, the stop code(s) are injected once when `rx_fill` >= 4*`cfg_halt_lvl`. Afterwards the go code(s) are injected once when `rx_fill` <= 4*`cfg_resume_lvl`. Single mode sends slot 2 or slot 0; double mode sends slots 2 then 3, or 0 then 1.
- R8: `inject_go` is high only while `tx_idle` is 1, and for at most one cycle per character. Each further character needs `tx_idle` to have been low in between. Injection goes ahead regardless of `tx_halt`.
- R9: The code registers (slot 0 go-1, 1 go-2, 2 stop-1, 3 stop-2) are written through `cfg_wr`/`cfg_wr_sel`/`cfg_wr_data`. They power up to 0x00 and are not changed by `rst`.
- R10: Synchronous active-high `rst` clears `tx_halt`, `fc_flag`, `rx_push`, any partial match and any pending injection.
- R11: A character that is not consumed appears on `rx_push`/`rx_push_data` for one cycle after the edge that samples `rx_valid`. With `cfg_rx_en`=0 every character is forwarded. Receive strobes are at least three cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for a code register |
| cfg_wr_sel | input | 2 | Code slot to write (0 go-1, 1 go-2, 2 stop-1, 3 stop-2) |
| cfg_wr_data | input | 8 | Code value to write |
| cfg_rx_en | input | 1 | Act on received flow control codes |
| cfg_tx_auto | input | 1 | Inject codes based on FIFO fill level |
| cfg_double | input | 1 | Two-character codes |
| cfg_irq_en | input | 1 | Allow a stop match to raise the status flag |
| cfg_wlen | input | 2 | Character length select for comparison |
| cfg_halt_lvl | input | 4 | Halt threshold in units of 4 entries |
| cfg_resume_lvl | input | 4 | Resume threshold in units of 4 entries |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_fill | input | 7 | Receive FIFO fill level |
| tx_idle | input | 1 | Transmitter can take a character |
| rx_push | output | 1 | Write strobe to the receive FIFO |
| rx_push_data | output | 8 | Character written to the receive FIFO |
| tx_halt | output | 1 | Pause the transmitter after the current character |
| inject_go | output | 1 | Transmitter must send `inject_char` next |
| inject_char | output | 8 | Flow control character to send |
| fc_flag | output | 1 | Stop-match status / interrupt |

## Verification
The hardest case to reach is the broken pair in double mode. It needs a held first character, a non-matching second one, and two forwarded pushes on consecutive cycles, all in the right order. The bench reaches it by sending a stop-1 followed by a plain character, and by sending a go-1 followed by plain data while halted. The scoreboard then expects both bytes in arrival order. The same care applies to injection while the transmitter is paused. There the bench first halts the transmitter with a received stop code and then raises the fill level to the threshold, so that the injected characters must appear although `tx_halt` is high.

// File: rtl/uart_swflow_pkg.sv
package uart_swflow_pkg;

    localparam int CHAR_W    = 8;
    localparam int LVL_W     = 4;
    localparam int LVL_SHIFT = 2;

    typedef enum logic [1:0] {
        SLOT_GO1   = 2'd0,
        SLOT_GO2   = 2'd1,
        SLOT_STOP1 = 2'd2,
        SLOT_STOP2 = 2'd3
    } slot_e;

    typedef struct packed {
        logic [CHAR_W-1:0] go1;
        logic [CHAR_W-1:0] go2;
        logic [CHAR_W-1:0] stop1;
        logic [CHAR_W-1:0] stop2;
    } fc_chars_t;

    typedef struct packed {
        logic              vld;
        logic              is_go;
        logic              is_stop;
        logic [CHAR_W-1:0] data;
    } held_t;

    typedef enum logic [1:0] {
        INJ_IDLE   = 2'd0,
        INJ_FIRST  = 2'd1,
        INJ_SECOND = 2'd2
    } inj_state_e;

    function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] wlen);
        return {CHAR_W{1'b1}} >> (2'd3 - wlen);
    endfunction

    function automatic logic same_char(input logic [CHAR_W-1:0] a,
                                       input logic [CHAR_W-1:0] b,
                                       input logic [1:0]        wlen);
        return ((a ^ b) & len_mask(wlen)) == '0;
    endfunction

endpackage

// File: rtl/uart_swflow_regs.sv
module uart_swflow_regs
    import uart_swflow_pkg::*;
(
    input  logic              clk,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [CHAR_W-1:0] data,
    output fc_chars_t         chars
);
    // Deliberately outside the reset domain: contents survive rst.
    fc_chars_t bank_q = '0;

    always_ff @(posedge clk) begin
        if (wr) begin
            unique case (slot_e'(sel))
                SLOT_GO1:   bank_q.go1   <= data;
                SLOT_GO2:   bank_q.go2   <= data;
                SLOT_STOP1: bank_q.stop1 <= data;
                SLOT_STOP2: bank_q.stop2 <= data;
                default:    bank_q.go1   <= bank_q.go1;
            endcase
        end
    end

    assign chars = bank_q;
endmodule

// File: rtl/uart_swflow_rxmatch.sv
module uart_swflow_rxmatch
    import uart_swflow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              dbl,
    input  logic [1:0]        wlen,
    input  logic              halted,
    input  fc_chars_t         chars,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              push,
    output logic [CHAR_W-1:0] push_data,
    output logic              stop_evt,
    output logic              go_evt
);
    held_t             held_q, held_n;
    held_t             spill_q, spill_n;
    logic              push_q, push_n;
    logic [CHAR_W-1:0] pdata_q, pdata_n;
    logic              m_stop1, m_stop2, m_go1, m_go2;

    always_comb begin
        m_stop1 = same_char(rx_data, chars.stop1, wlen);
        m_stop2 = same_char(rx_data, chars.stop2, wlen);
        m_go1   = halted && same_char(rx_data, chars.go1, wlen);
        m_go2   = same_char(rx_data, chars.go2, wlen);
    end

    always_comb begin
        stop_evt = 1'b0;
        go_evt   = 1'b0;
        push_n   = 1'b0;
        pdata_n  = rx_data;
        held_n   = held_q;
        spill_n  = '0;
        // Second half of a broken pair drains one cycle late.
        if (spill_q.vld) begin
            push_n  = 1'b1;
            pdata_n = spill_q.data;
        end
        if (rx_valid) begin
            if (!en) begin
                push_n = 1'b1;
            end else if (!dbl) begin
                if (m_stop1)    stop_evt = 1'b1;
                else if (m_go1) go_evt   = 1'b1;
                else            push_n   = 1'b1;
            end else if (!held_q.vld) begin
                if (m_stop1 || m_go1) held_n = '{vld: 1'b1, is_go: m_go1, is_stop: m_stop1, data: rx_data};
                else                  push_n = 1'b1;
            end else begin
                held_n = '0;
                if (held_q.is_stop && m_stop2) begin
                    stop_evt = 1'b1;
                end else if (held_q.is_go && m_go2) begin
                    go_evt = 1'b1;
                end else begin
                    push_n  = 1'b1;
                    pdata_n = held_q.data;
                    spill_n = '{vld: 1'b1, is_go: 1'b0, is_stop: 1'b0, data: rx_data};
                end
            end
        end
        if (!(en && dbl)) held_n.vld = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q  <= '0;
            spill_q <= '0;
            push_q  <= 1'b0;
            pdata_q <= '0;
        end else begin
            held_q  <= held_n;
            spill_q <= spill_n;
            push_q  <= push_n;
            pdata_q <= pdata_n;
        end
    end

    assign push      = push_q;
    assign push_data = pdata_q;
endmodule

// File: rtl/uart_swflow_level.sv
module uart_swflow_level
    import uart_swflow_pkg::*;
#(
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en,
    input  logic [FILL_W-1:0] fill,
    input  logic [LVL_W-1:0]  halt_lvl,
    input  logic [LVL_W-1:0]  resume_lvl,
    output logic              req,
    output logic              req_go
);
    logic [FILL_W-1:0] halt_cnt, resume_cnt;
    logic              remote_off_q;

    always_comb begin
        halt_cnt   = FILL_W'(halt_lvl)   << LVL_SHIFT;
        resume_cnt = FILL_W'(resume_lvl) << LVL_SHIFT;
        req    = 1'b0;
        req_go = 1'b0;
        if (auto_en) begin
            if (!remote_off_q && fill >= halt_cnt) begin
                req = 1'b1;
            end else if (remote_off_q && fill <= resume_cnt) begin
                req    = 1'b1;
                req_go = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)      remote_off_q <= 1'b0;
        else if (req) remote_off_q <= !req_go;
    end
endmodule

// File: rtl/uart_swflow_inject.sv
module uart_swflow_inject
    import uart_swflow_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_go,
    input  logic              dbl,
    input  fc_chars_t         chars,
    input  logic              tx_idle,
    output logic              go,
    output logic [CHAR_W-1:0] char_out
);
    inj_state_e state_q;
    logic       kind_go_q;
    logic       armed_q;

    always_comb begin
        go = (state_q != INJ_IDLE) && tx_idle && armed_q;
        if (kind_go_q) char_out = (state_q == INJ_SECOND) ? chars.go2   : chars.go1;
        else           char_out = (state_q == INJ_SECOND) ? chars.stop2 : chars.stop1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= INJ_IDLE;
            kind_go_q <= 1'b0;
            armed_q   <= 1'b1;
        end else begin
            if (req) begin
                state_q   <= INJ_FIRST;
                kind_go_q <= req_go;
            end else if (go) begin
                state_q <= (state_q == INJ_FIRST && dbl) ? INJ_SECOND : INJ_IDLE;
            end
            if (go)           armed_q <= 1'b0;
            else if (!tx_idle) armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/uart_swflow.sv
module uart_swflow
    import uart_swflow_pkg::*;
#(
    parameter int FILL_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [7:0]        cfg_wr_data,
    input  logic              cfg_rx_en,
    input  logic              cfg_tx_auto,
    input  logic              cfg_double,
    input  logic              cfg_irq_en,
    input  logic [1:0]        cfg_wlen,
    input  logic [3:0]        cfg_halt_lvl,
    input  logic [3:0]        cfg_resume_lvl,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic              tx_idle,
    output logic              rx_push,
    output logic [7:0]        rx_push_data,
    output logic              tx_halt,
    output logic              inject_go,
    output logic [7:0]        inject_char,
    output logic              fc_flag
);
    fc_chars_t chars;
    logic      stop_evt, go_evt;
    logic      lvl_req, lvl_req_go;
    logic      halt_q, flag_q;

    uart_swflow_regs u_regs (
        .clk   (clk),
        .wr    (cfg_wr),
        .sel   (cfg_wr_sel),
        .data  (cfg_wr_data),
        .chars (chars)
    );

    uart_swflow_rxmatch u_rx (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_rx_en),
        .dbl       (cfg_double),
        .wlen      (cfg_wlen),
        .halted    (halt_q),
        .chars     (chars),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .push      (rx_push),
        .push_data (rx_push_data),
        .stop_evt  (stop_evt),
        .go_evt    (go_evt)
    );

    uart_swflow_level #(.FILL_W(FILL_W)) u_lvl (
        .clk        (clk),
        .rst        (rst),
        .auto_en    (cfg_tx_auto),
        .fill       (rx_fill),
        .halt_lvl   (cfg_halt_lvl),
        .resume_lvl (cfg_resume_lvl),
        .req        (lvl_req),
        .req_go     (lvl_req_go)
    );

    uart_swflow_inject u_inj (
        .clk      (clk),
        .rst      (rst),
        .req      (lvl_req),
        .req_go   (lvl_req_go),
        .dbl      (cfg_double),
        .chars    (chars),
        .tx_idle  (tx_idle),
        .go       (inject_go),
        .char_out (inject_char)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            flag_q <= 1'b0;
        end else if (stop_evt) begin
            halt_q <= 1'b1;
            flag_q <= flag_q | cfg_irq_en;
        end else if (go_evt) begin
            halt_q <= 1'b0;
            flag_q <= 1'b0;
        end
    end

    assign tx_halt = halt_q;
    assign fc_flag = flag_q;
endmodule

// File: rtl/uart_swflow_chk.sv
module uart_swflow_chk
    import uart_swflow_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cfg_rx_en,
    input logic       cfg_double,
    input logic       cfg_irq_en,
    input logic [1:0] cfg_wlen,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_push,
    input logic       tx_idle,
    input logic       tx_halt,
    input logic       inject_go,
    input logic       fc_flag,
    input fc_chars_t  chars
);
    p_go_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
        inject_go |-> tx_idle);

    p_go_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        inject_go |=> !inject_go);

    p_flag_implies_halt_r6: assert property (@(posedge clk) disable iff (rst)
        fc_flag |-> tx_halt);

    p_flag_rise_enabled_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(fc_flag) |-> $past(cfg_irq_en));

    p_halt_rise_on_rx_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_halt) |-> $past(rx_valid));

    p_halt_fall_on_rx_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_halt) |-> $past(rx_valid));

    p_stop_swallowed_r1: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && cfg_rx_en && !cfg_double && same_char(rx_data, chars.stop1, cfg_wlen))
        |=> !rx_push);
endmodule

bind uart_swflow uart_swflow_chk chk_i (.*);

// File: tb/uart_swflow_tb_top.sv
module uart_swflow_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_wr_sel = '0;
    logic [7:0] cfg_wr_data = '0;
    logic       cfg_rx_en = 1'b0, cfg_tx_auto = 1'b0, cfg_double = 1'b0, cfg_irq_en = 1'b0;
    logic [1:0] cfg_wlen = 2'd3;
    logic [3:0] cfg_halt_lvl = '0, cfg_resume_lvl = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [6:0] rx_fill = '0;
    logic       tx_idle = 1'b1;
    logic       rx_push, tx_halt, inject_go, fc_flag;
    logic [7:0] rx_push_data, inject_char;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;
    logic [7:0] rx_exp_q[$];
    logic [7:0] inj_exp_q[$];

    always #5 clk = ~clk;

    uart_swflow dut_i (.*);

    task automatic check(input logic ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_code(input logic [1:0] sel, input logic [7:0] val);
        @(posedge clk); #1;
        cfg_wr = 1'b1; cfg_wr_sel = sel; cfg_wr_data = val;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    // Driver: pushes the expected FIFO write (if any) into the scoreboard.
    task automatic rx_char(input logic [7:0] d, input bit fwd);
        if (fwd) rx_exp_q.push_back(d);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = d;
        @(posedge clk); #1;
        rx_valid = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    task automatic check_state(input string req, input logic halt_e, input logic flag_e);
        @(negedge clk);
        check(tx_halt == halt_e, req, tx_halt, halt_e);
        check(fc_flag == flag_e, req, fc_flag, flag_e);
    endtask

    // Monitor: compares FIFO writes and injected characters against the queues.
    always @(negedge clk) begin
        if (!rst && rx_push) begin
            if (rx_exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected push", rx_push_data, 0);
            end else begin
                logic [7:0] e;
                e = rx_exp_q.pop_front();
                check(rx_push_data == e, "R4/R11 push data", rx_push_data, e);
            end
        end
        if (!rst && inject_go) begin
            check(tx_idle == 1'b1, "R8 inject while busy", tx_idle, 1);
            if (inj_exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected inject", inject_char, 0);
            end else begin
                logic [7:0] e;
                e = inj_exp_q.pop_front();
                check(inject_char == e, "R7 inject char", inject_char, e);
            end
        end
    end

    // Transmitter model: busy for three cycles after taking a character.
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && inject_go) begin
                @(posedge clk); #1 tx_idle = 1'b0;
                repeat (3) @(posedge clk);
                #1 tx_idle = 1'b1;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(tx_halt == 0 && fc_flag == 0 && rx_push == 0 && inject_go == 0,
              "R10 reset state", {tx_halt, fc_flag, rx_push, inject_go}, 0);

        // R9: codes power up to 0x00, so a 0x00 character is a stop code.
        cfg_rx_en = 1'b1; cfg_irq_en = 1'b1;
        rx_char(8'h00, 0);
        check_state("R9 power-up stop code 0x00", 1, 1);

        wr_code(2'd0, 8'h11);
        wr_code(2'd1, 8'h12);
        wr_code(2'd2, 8'h13);
        wr_code(2'd3, 8'h14);
        rx_char(8'h11, 0);
        check_state("R2 go code resumes", 0, 0);

        // R11 / R2: plain data and a go code while running are forwarded.
        rx_char(8'h41, 1);
        rx_char(8'h11, 1);
        check_state("R2 go code while running forwarded", 0, 0);

        // R1 single-mode stop, then a repeated stop and a resume.
        rx_char(8'h13, 0);
        check_state("R1 stop halts", 1, 1);
        rx_char(8'h42, 1);
        rx_char(8'h11, 0);
        check_state("R2 resume clears flag", 0, 0);

        // R6: flag held back when interrupt enable is clear.
        cfg_irq_en = 1'b0;
        rx_char(8'h13, 0);
        check_state("R6 halt without flag", 1, 0);
        rx_char(8'h11, 0);
        check_state("R6 resume", 0, 0);
        cfg_irq_en = 1'b1;

        // R5: 5-bit compare matches on low bits only; 8-bit compare does not.
        cfg_wlen = 2'd0;
        rx_char(8'hF3, 0);
        check_state("R5 5-bit stop match", 1, 1);
        rx_char(8'hF1, 0);
        check_state("R5 5-bit go match", 0, 0);
        cfg_wlen = 2'd3;
        rx_char(8'hF3, 1);
        check_state("R5 8-bit no match", 0, 0);

        // R3 double mode pairs.
        cfg_double = 1'b1;
        rx_char(8'h13, 0);
        rx_char(8'h14, 0);
        check_state("R3 stop pair halts", 1, 1);
        // R4: broken go pair while halted, both forwarded, still halted.
        rx_char(8'h11, 1);
        rx_char(8'h55, 1);
        check_state("R4 broken go pair keeps halt", 1, 1);
        rx_char(8'h11, 0);
        rx_char(8'h12, 0);
        check_state("R3 go pair resumes", 0, 0);
        // R4: broken stop pair.
        rx_char(8'h13, 1);
        rx_char(8'h41, 1);
        check_state("R4 broken stop pair no halt", 0, 0);

        // R11: receive flow control disabled forwards codes.
        cfg_rx_en = 1'b0; cfg_double = 1'b0;
        rx_char(8'h13, 1);
        check_state("R11 disabled forwards stop code", 0, 0);
        cfg_rx_en = 1'b1;

        // R7/R8 single-mode injection, while halted by a received stop.
        rx_char(8'h13, 0);
        check_state("R8 halted before injection", 1, 1);
        cfg_halt_lvl = 4'd2; cfg_resume_lvl = 4'd1;
        rx_fill = 7'd5;
        @(posedge clk); #1 cfg_tx_auto = 1'b1;
        repeat (10) @(posedge clk);
        check(inj_exp_q.size() == 0, "R7 no inject below halt level", 0, 0);
        inj_exp_q.push_back(8'h13);
        #1 rx_fill = 7'd8;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(inj_exp_q.size() == 0, "R8 stop injected while halted", inj_exp_q.size(), 0);
        check(tx_halt == 1, "R8 halt unaffected by injection", tx_halt, 1);
        #1 rx_fill = 7'd6;
        repeat (10) @(posedge clk);
        inj_exp_q.push_back(8'h11);
        #1 rx_fill = 7'd4;
        repeat (12) @(posedge clk);
        @(negedge clk);
        check(inj_exp_q.size() == 0, "R7 go injected at resume level", inj_exp_q.size(), 0);

        // R7 double mode: two-character codes.
        cfg_double = 1'b1;
        inj_exp_q.push_back(8'h13);
        inj_exp_q.push_back(8'h14);
        #1 rx_fill = 7'd9;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(inj_exp_q.size() == 0, "R7 stop pair injected", inj_exp_q.size(), 0);
        inj_exp_q.push_back(8'h11);
        inj_exp_q.push_back(8'h12);
        #1 rx_fill = 7'd0;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(inj_exp_q.size() == 0, "R7 go pair injected", inj_exp_q.size(), 0);
        #1 cfg_tx_auto = 1'b0; cfg_double = 1'b0;

        // R10 / R9: reset clears halt but keeps the codes.
        @(posedge clk); #1 rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check_state("R10 reset clears halt and flag", 0, 0);
        rx_char(8'h13, 0);
        check_state("R9 codes kept across reset", 1, 1);
        rx_char(8'h11, 0);
        check_state("R9 go code kept across reset", 0, 0);

        repeat (5) @(posedge clk);
        check(rx_exp_q.size() == 0, "R11 all forwarded characters seen", rx_exp_q.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule